// File: doc/BRIEF.md
# Seconds Countdown Alarm

The block is a relative alarm that sits beside a real-time clock. Software loads an interval in seconds. While counting is enabled, the block subtracts one from a live remaining count on each one-second tick pulse. When the count steps from one to zero, the block sets a sticky pending flag and stops counting. The pending flag drives an interrupt line when the interrupt is enabled, and a wakeup line when wakeup is enabled.

Software reaches the block through a simple register interface. It writes with a one-cycle write strobe, address and data, and reads through a combinational read port. The register set covers the interval, a readback of the remaining count, a counting enable, an interrupt enable, a write-one-to-clear status, and a wakeup enable. The set also holds three stub registers for a second alarm: an enable, an interrupt enable and a status. To rearm, software writes the interval again, and every write restarts the countdown from the written value.

Top module: `alarm_top`

## Requirements
- R1: After reset, every register reads as zero, and both `irq` and `wake` are low.
- R2: A write to offset 0x20 stores the value. From the next cycle, both 0x20 and the remaining count at 0x24 read back the written value, which restarts any countdown in progress.
- R3: While bit 0 of offset 0x28 is 1, each clock edge with `tick` high lowers a nonzero remaining count by exactly one. While that bit is 0, ticks leave the count frozen.
- R4: The tick that takes the count from 1 to 0 sets the pending flag (bit 0 of 0x30) at the same edge. The count then stays at 0, and pending is not set again until the interval is rewritten.
- R5: An interval of zero never sets the pending flag, however many ticks arrive.
- R6: Writing 1 to bit 0 of 0x30 clears the pending flag, and writing 0 leaves it unchanged. If a clear and an expiry fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly while the pending flag and bit 0 of 0x2C are both 1.
- R8: `wake` is high exactly while the pending flag and bit 0 of 0x50 are both 1.
- R9: The second-alarm enable (0x44) and interrupt enable (0x48) store and read back bit 0 of the write data. Its status at 0x4C always reads 0 and accepts write-one-to-clear. None of the three affects `irq` or `wake`.
- R10: The control registers keep only bit 0, so their upper bits read 0. Any offset that is not mapped reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse per second |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
The hardest case to reach from the ports is an expiry tick that lands on the same edge as a software clear of the pending flag, because the result depends on which of the two wins. The stimulus loads an interval of one with counting enabled. It then raises `tick` and drives a write-one-to-clear of the status in the same cycle, and afterwards reads back both the flag and the count. A second test freezes the count mid-way by dropping the enable and sends several ticks before resuming, so that the pause can be seen in the remaining count.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int ADDR_W = 8;

    // Register offsets; software decodes these, so they are fixed
    localparam logic [ADDR_W-1:0] OFS_INTERVAL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_REMAIN    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT_EN    = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_PEND      = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_WK_EN     = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_WK_IRQ_EN = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_WK_PEND   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_WAKE_CFG  = 8'h50;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_INTERVAL,
        SEL_REMAIN,
        SEL_CNT_EN,
        SEL_IRQ_EN,
        SEL_PEND,
        SEL_WK_EN,
        SEL_WK_IRQ_EN,
        SEL_WK_PEND,
        SEL_WAKE_CFG
    } reg_sel_e;

    typedef struct packed {
        logic cnt_en;
        logic irq_en;
        logic wake_en;
        logic wk_en;
        logic wk_irq_en;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_INTERVAL:  return SEL_INTERVAL;
            OFS_REMAIN:    return SEL_REMAIN;
            OFS_CNT_EN:    return SEL_CNT_EN;
            OFS_IRQ_EN:    return SEL_IRQ_EN;
            OFS_PEND:      return SEL_PEND;
            OFS_WK_EN:     return SEL_WK_EN;
            OFS_WK_IRQ_EN: return SEL_WK_IRQ_EN;
            OFS_WK_PEND:   return SEL_WK_PEND;
            OFS_WAKE_CFG:  return SEL_WAKE_CFG;
            default:       return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    output logic [CNT_W-1:0]  interval_q,
    output ctrl_t             ctrl_q,
    output logic              pend_q,
    output logic              wk_pend_q,
    output logic              load,
    output logic              pend_clr
);

    logic wk_clr;

    assign load     = wen && (sel == SEL_INTERVAL);
    assign pend_clr = wen && (sel == SEL_PEND) && wdata[0];
    assign wk_clr   = wen && (sel == SEL_WK_PEND) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= '0;
        end else if (load) begin
            interval_q <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wen) begin
            case (sel)
                SEL_CNT_EN:    ctrl_q.cnt_en    <= wdata[0];
                SEL_IRQ_EN:    ctrl_q.irq_en    <= wdata[0];
                SEL_WAKE_CFG:  ctrl_q.wake_en   <= wdata[0];
                SEL_WK_EN:     ctrl_q.wk_en     <= wdata[0];
                SEL_WK_IRQ_EN: ctrl_q.wk_irq_en <= wdata[0];
                default: ;
            endcase
        end
    end

    // Expiry wins over a clear on the same edge (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (pend_clr) begin
            pend_q <= 1'b0;
        end
    end

    // Second-alarm status: no source in this block, clear-only
    always_ff @(posedge clk) begin
        if (rst || wk_clr) begin
            wk_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             en,
    output logic [CNT_W-1:0] remain_q,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step = tick && en && (remain_q != '0) && !load;
    assign hit  = step && (remain_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (step) begin
            remain_q <= remain_q - ONE;
        end
    end

endmodule

// File: rtl/alarm_readmux.sv
module alarm_readmux
    import alarm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  reg_sel_e          sel,
    input  logic [CNT_W-1:0]  interval_q,
    input  logic [CNT_W-1:0]  remain_q,
    input  ctrl_t             ctrl_q,
    input  logic              pend_q,
    input  logic              wk_pend_q,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] interval_ext;
    logic [DATA_W-1:0] remain_ext;

    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign interval_ext = {{(DATA_W-CNT_W){1'b0}}, interval_q};
            assign remain_ext   = {{(DATA_W-CNT_W){1'b0}}, remain_q};
        end else begin : g_full
            assign interval_ext = interval_q;
            assign remain_ext   = remain_q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_INTERVAL:  rdata = interval_ext;
            SEL_REMAIN:    rdata = remain_ext;
            SEL_CNT_EN:    rdata[0] = ctrl_q.cnt_en;
            SEL_IRQ_EN:    rdata[0] = ctrl_q.irq_en;
            SEL_PEND:      rdata[0] = pend_q;
            SEL_WK_EN:     rdata[0] = ctrl_q.wk_en;
            SEL_WK_IRQ_EN: rdata[0] = ctrl_q.wk_irq_en;
            SEL_WK_PEND:   rdata[0] = wk_pend_q;
            SEL_WAKE_CFG:  rdata[0] = ctrl_q.wake_en;
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/alarm_top.sv
module alarm_top
    import alarm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);

    reg_sel_e         sel;
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] remain_q;
    ctrl_t            ctrl_q;
    logic             pend_q;
    logic             wk_pend_q;
    logic             load;
    logic             pend_clr;
    logic             hit;

    assign sel = decode_addr(bus_addr);

    alarm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wen        (bus_wen),
        .sel        (sel),
        .wdata      (bus_wdata),
        .hit        (hit),
        .interval_q (interval_q),
        .ctrl_q     (ctrl_q),
        .pend_q     (pend_q),
        .wk_pend_q  (wk_pend_q),
        .load       (load),
        .pend_clr   (pend_clr)
    );

    alarm_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (tick),
        .en       (ctrl_q.cnt_en),
        .remain_q (remain_q),
        .hit      (hit)
    );

    alarm_readmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
        .sel        (sel),
        .interval_q (interval_q),
        .remain_q   (remain_q),
        .ctrl_q     (ctrl_q),
        .pend_q     (pend_q),
        .wk_pend_q  (wk_pend_q),
        .rdata      (bus_rdata)
    );

    assign irq  = pend_q && ctrl_q.irq_en;
    assign wake = pend_q && ctrl_q.wake_en;

endmodule

// File: rtl/alarm_chk.sv
module alarm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cnt_en,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] remain_q,
    input logic             pend_q,
    input logic             pend_clr,
    input logic             irq,
    input logic             wake
);

    p_reload_r2: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> remain_q == $past(load_val));

    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && (!$past(tick) || !$past(cnt_en))) |-> $stable(remain_q));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> (remain_q == $past(remain_q)
                          || remain_q == $past(remain_q) - CNT_W'(1)));

    p_expiry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> (remain_q == '0 && $past(remain_q) == CNT_W'(1)));

    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(pend_clr));

    p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend_q);

    p_wake_src_r8: assert property (@(posedge clk) disable iff (rst)
        wake |-> pend_q);

endmodule

bind alarm_top alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_en   (ctrl_q.cnt_en),
    .load     (load),
    .load_val (bus_wdata[CNT_W-1:0]),
    .remain_q (remain_q),
    .pend_q   (pend_q),
    .pend_clr (pend_clr),
    .irq      (irq),
    .wake     (wake)
);

// File: tb/alarm_top_bench.sv
module alarm_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wake;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_INT = 8'h20, A_REM = 8'h24, A_EN = 8'h28,
        A_IE = 8'h2C, A_PND = 8'h30, A_WEN = 8'h44, A_WIE = 8'h48,
        A_WPD = 8'h4C, A_WAK = 8'h50;

    always #5 clk = ~clk;

    alarm_top u_alarm_top (
        .clk(clk), .rst(rst), .tick(tick), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic t_reset;
        rd_chk("R1 interval", A_INT, 0);
        rd_chk("R1 remain", A_REM, 0);
        rd_chk("R1 enable", A_EN, 0);
        rd_chk("R1 pending", A_PND, 0);
        rd_chk("R1 wake cfg", A_WAK, 0);
        rd_chk("R1 stub enable", A_WEN, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 wake", {31'b0, wake}, 0);
    endtask

    task automatic t_countdown;
        wr(A_INT, 5);
        rd_chk("R2 interval readback", A_INT, 5);
        rd_chk("R2 remain loaded", A_REM, 5);
        wr(A_EN, 1);
        ticks(2);
        rd_chk("R3 decrement", A_REM, 3);
        wr(A_EN, 0);
        ticks(3);
        rd_chk("R3 frozen", A_REM, 3);
        wr(A_EN, 1);
        ticks(2);
        rd_chk("R4 not yet", A_PND, 0);
        ticks(1);
        rd_chk("R4 expiry pending", A_PND, 1);
        rd_chk("R4 remain zero", A_REM, 0);
        check("R7 irq off while disabled", {31'b0, irq}, 0);
        wr(A_IE, 1);
        #1 check("R7 irq on", {31'b0, irq}, 1);
        check("R8 wake off", {31'b0, wake}, 0);
        wr(A_WAK, 1);
        #1 check("R8 wake on", {31'b0, wake}, 1);
        wr(A_PND, 0);
        rd_chk("R6 write zero keeps", A_PND, 1);
        wr(A_PND, 1);
        rd_chk("R6 clear", A_PND, 0);
        check("R7 irq follows clear", {31'b0, irq}, 0);
        check("R8 wake follows clear", {31'b0, wake}, 0);
        ticks(3);
        rd_chk("R4 stays zero", A_REM, 0);
        rd_chk("R4 no re-set", A_PND, 0);
    endtask

    task automatic t_zero_interval;
        wr(A_INT, 0);
        ticks(4);
        rd_chk("R5 zero interval no pending", A_PND, 0);
        rd_chk("R5 remain zero", A_REM, 0);
    endtask

    task automatic t_reload;
        wr(A_INT, 10);
        ticks(3);
        rd_chk("R3 mid count", A_REM, 7);
        wr(A_INT, 4);
        rd_chk("R2 restart", A_REM, 4);
        wr(A_INT, 32'hFFFF_FFFF);
        ticks(1);
        rd_chk("R2 full width", A_REM, 32'hFFFF_FFFE);
    endtask

    task automatic t_set_wins;
        wr(A_INT, 1);
        @(negedge clk);
        tick = 1'b1; bus_wen = 1'b1; bus_addr = A_PND; bus_wdata = 1;
        @(negedge clk);
        tick = 1'b0; bus_wen = 1'b0;
        rd_chk("R6 expiry beats clear", A_PND, 1);
        rd_chk("R4 remain zero", A_REM, 0);
        wr(A_PND, 1);
    endtask

    task automatic t_stub;
        wr(A_WEN, 32'hFFFF_FFFF);
        rd_chk("R9 stub enable", A_WEN, 1);
        wr(A_WIE, 1);
        rd_chk("R9 stub irq enable", A_WIE, 1);
        wr(A_WPD, 1);
        rd_chk("R9 stub status", A_WPD, 0);
        check("R9 no irq", {31'b0, irq}, 0);
        check("R9 no wake", {31'b0, wake}, 0);
    endtask

    task automatic t_map;
        rd_chk("R10 unmapped", 8'h10, 0);
        wr(A_IE, 32'hFFFF_FFFE);
        rd_chk("R10 bit0 only", A_IE, 0);
        wr(A_EN, 32'h8000_0001);
        rd_chk("R10 upper bits dropped", A_EN, 1);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_countdown();
        t_zero_interval();
        t_reload();
        t_set_wins();
        t_stub();
        t_map();
        summary();
    end

endmodule